// File: doc/BRIEF.md
# Packed graphics tag parser

This block sits on a single 128-bit quadword stream that carries drawing data toward a graphics back end. The stream is split into packets. Each packet opens with one header quadword (the tag) that says how many payload quadwords follow and how they are to be read. The parser takes the tag in, keeps its fields, and then sends each payload quadword out with the 4-bit register descriptor that belongs to it. When the payload of a packet is finished it expects a fresh tag. When a packet whose end flag is set has been fully consumed, the parser stops taking input until it is re-armed.

Only the packed format produces output. Tags in the register-list or image format raise a one-cycle flag, and their payload is taken from the input and thrown away. Both sides use valid/ready handshakes. In the packed phase the input path passes straight through to the output, so back-pressure from the sink reaches the source in the same cycle.

Top module: `gpk_tag_parser`

## Requirements
- R1: Reset (synchronous, active high) leaves the parser waiting for a tag: in_ready is 1, out_valid is 0 and bad_fmt is 0.
- R2: Tag layout: loop count in bits 14:0, end flag in bit 15, format in bits 59:58 (00 packed, 01 register-list, 10 and 11 image), register count in bits 63:60, descriptor array in bits 127:64. A tag quadword is always accepted while waiting for a tag, and it never appears on the output.
- R3: In packed format exactly loop count × register count payload quadwords are sent out, each with out_data equal to the input quadword.
- R4: Payload beat k (counting from 0) carries the descriptor found in tag bits 64+4·(k mod N) upward, where N is the register count and a register count of 0 means N = 16.
- R5: out_last is 1 only on the final payload beat of a packed packet.
- R6: A loop count of 0 means the packet has no payload: the next quadword is read as a tag, or the parser goes idle if the end flag is set.
- R7: After the last quadword of a packet whose end flag is 1, in_ready stays 0 and nothing is output until arm is pulsed; after that pulse the parser waits for a tag again.
- R8: A register-list or image tag drives bad_fmt to 1 for exactly the cycle after the tag is accepted. The parser then discards, with out_valid held at 0, ceil(loop count × register count / 2) quadwords for register-list or loop count quadwords for image.
- R9: During the packed payload, out_valid follows in_valid and in_ready follows out_ready. While the sink stalls, out_desc stays the same, and no quadword is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restarts tag parsing after an end-flagged packet |
| in_valid | input | 1 | Input quadword is valid |
| in_ready | output | 1 | Parser accepts the input quadword |
| in_data | input | 128 | Input quadword (tag or payload) |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 128 | Payload quadword |
| out_desc | output | 4 | Register descriptor for this payload quadword |
| out_last | output | 1 | Final payload beat of the packet |
| bad_fmt | output | 1 | One-cycle pulse after a tag in a format other than packed |

## Verification
The bench builds the block with the package defaults: 16 descriptor slots of 4 bits and a 15-bit loop count. These widths make the full 16-entry descriptor wrap reachable through a register count of 0, and they give register-list discard counts with odd products. The stimulus table mixes packed tags that repeat the descriptor sequence, a zero-loop tag, both discard formats and three end-flagged packets. Sink stalls are inserted every third beat to check that the descriptor is held and that nothing is lost.

// File: rtl/gpk_pkg.sv
package gpk_pkg;

    localparam int QW_W     = 128;
    localparam int DESC_W   = 4;
    localparam int NDESC    = 16;
    localparam int LOOP_W   = 15;
    localparam int NREG_W   = 4;
    localparam int IDX_W    = $clog2(NDESC);
    localparam int SKIP_W   = LOOP_W + NREG_W + 1;
    localparam int DARR_W   = NDESC * DESC_W;

    localparam int LOOP_LSB = 0;
    localparam int EOP_BIT  = 15;
    localparam int FMT_LSB  = 58;
    localparam int NREG_LSB = 60;
    localparam int DESC_LSB = 64;

    typedef enum logic [1:0] {
        FMT_PACKED  = 2'b00,
        FMT_REGLIST = 2'b01,
        FMT_IMAGE   = 2'b10,
        FMT_IMAGE2  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG,
        ST_PACK,
        ST_SKIP
    } st_e;

    typedef struct packed {
        logic [DARR_W-1:0] descs;
        logic [NREG_W-1:0] nreg_m1;
        logic              eop;
        fmt_e              fmt;
        logic [LOOP_W-1:0] nloop;
        logic [SKIP_W-1:0] skip_len;
    } tag_t;

    function automatic logic [NREG_W:0] nreg_count(logic [NREG_W-1:0] f);
        return (f == '0) ? (NREG_W+1)'(NDESC) : {1'b0, f};
    endfunction

    function automatic logic [SKIP_W-1:0] discard_len(fmt_e f,
                                                      logic [LOOP_W-1:0] nl,
                                                      logic [NREG_W:0] nr);
        logic [SKIP_W-1:0] prod;
        prod = SKIP_W'(nl) * SKIP_W'(nr);
        case (f)
            FMT_PACKED:  return '0;
            FMT_REGLIST: return (prod + SKIP_W'(1)) >> 1;
            default:     return SKIP_W'(nl);
        endcase
    endfunction

endpackage

// File: rtl/gpk_tag_decode.sv
module gpk_tag_decode
    import gpk_pkg::*;
(
    input  logic [QW_W-1:0] qw,
    output tag_t            tag
);
    logic [NREG_W-1:0] nreg_field;
    logic              unused_gap;

    assign nreg_field = qw[NREG_LSB +: NREG_W];
    assign unused_gap = ^qw[FMT_LSB-1:EOP_BIT+1];

    always_comb begin
        tag.nloop    = qw[LOOP_LSB +: LOOP_W];
        tag.eop      = qw[EOP_BIT];
        tag.fmt      = fmt_e'(qw[FMT_LSB +: 2]);
        tag.nreg_m1  = nreg_field - NREG_W'(1);
        tag.descs    = qw[DESC_LSB +: DARR_W];
        tag.skip_len = discard_len(tag.fmt, tag.nloop, nreg_count(nreg_field));
    end
endmodule

// File: rtl/gpk_desc_sel.sv
module gpk_desc_sel
    import gpk_pkg::*;
(
    input  logic [DARR_W-1:0] descs,
    input  logic [IDX_W-1:0]  idx,
    output logic [DESC_W-1:0] desc
);
    logic [DESC_W-1:0] slots [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_slot
        assign slots[g] = descs[g*DESC_W +: DESC_W];
    end

    assign desc = slots[idx];
endmodule

// File: rtl/gpk_beat_ctr.sv
module gpk_beat_ctr
    import gpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NREG_W-1:0] nreg_m1,
    input  logic [LOOP_W-1:0] nloop,
    input  logic              step,
    output logic [IDX_W-1:0]  idx,
    output logic              last_beat
);
    logic [NREG_W-1:0] nm1_q;
    logic [LOOP_W-1:0] loop_rem;
    logic              wrap;

    assign wrap      = (NREG_W'(idx) == nm1_q);
    assign last_beat = wrap && (loop_rem == LOOP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            nm1_q    <= '0;
            loop_rem <= '0;
        end else if (load) begin
            idx      <= '0;
            nm1_q    <= nreg_m1;
            loop_rem <= nloop;
        end else if (step) begin
            if (wrap) begin
                idx      <= '0;
                loop_rem <= loop_rem - LOOP_W'(1);
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // descriptor index never passes the register count of the tag
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        NREG_W'(idx) <= nm1_q);
endmodule

// File: rtl/gpk_tag_parser.sv
module gpk_tag_parser
    import gpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [QW_W-1:0]   in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QW_W-1:0]   out_data,
    output logic [DESC_W-1:0] out_desc,
    output logic              out_last,
    output logic              bad_fmt
);
    st_e               st, st_nx;
    tag_t              tag;
    logic [DARR_W-1:0] descs_q;
    logic              eop_q;
    logic [SKIP_W-1:0] skip_rem;
    logic [IDX_W-1:0]  idx;
    logic              last_beat;
    logic              tag_fire, beat_fire, skip_fire;
    st_e               after_pkt;

    gpk_tag_decode u_dec (
        .qw  (in_data),
        .tag (tag)
    );

    gpk_beat_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (tag_fire),
        .nreg_m1   (tag.nreg_m1),
        .nloop     (tag.nloop),
        .step      (beat_fire),
        .idx       (idx),
        .last_beat (last_beat)
    );

    gpk_desc_sel u_sel (
        .descs (descs_q),
        .idx   (idx),
        .desc  (out_desc)
    );

    assign in_ready  = (st == ST_TAG) || (st == ST_SKIP) || ((st == ST_PACK) && out_ready);
    assign out_valid = (st == ST_PACK) && in_valid;
    assign out_data  = in_data;
    assign out_last  = out_valid && last_beat;

    assign tag_fire  = (st == ST_TAG) && in_valid;
    assign beat_fire = out_valid && out_ready;
    assign skip_fire = (st == ST_SKIP) && in_valid;
    assign after_pkt = eop_q ? ST_IDLE : ST_TAG;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (arm) st_nx = ST_TAG;
            ST_TAG: begin
                if (in_valid) begin
                    if (tag.nloop == '0)
                        st_nx = tag.eop ? ST_IDLE : ST_TAG;
                    else if (tag.fmt == FMT_PACKED)
                        st_nx = ST_PACK;
                    else
                        st_nx = ST_SKIP;
                end
            end
            ST_PACK: if (beat_fire && last_beat) st_nx = after_pkt;
            ST_SKIP: if (skip_fire && (skip_rem == SKIP_W'(1))) st_nx = after_pkt;
            default: st_nx = ST_TAG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_TAG;
            bad_fmt  <= 1'b0;
            eop_q    <= 1'b0;
            descs_q  <= '0;
            skip_rem <= '0;
        end else begin
            st      <= st_nx;
            bad_fmt <= tag_fire && (tag.fmt != FMT_PACKED);
            if (tag_fire) begin
                eop_q    <= tag.eop;
                descs_q  <= tag.descs;
                skip_rem <= tag.skip_len;
            end else if (skip_fire) begin
                skip_rem <= skip_rem - SKIP_W'(1);
            end
        end
    end

    // a stalled beat keeps its descriptor
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_desc));

    // back-pressure reaches the source in the same cycle
    assert_ready_follow_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_ready == out_ready));

    // after the final beat the next quadword is never a payload beat
    assert_last_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // idle holds off input until re-armed
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_IDLE) && !arm) |=> !in_ready);

    // an unsupported tag produces no output beat
    assert_bad_no_out_R8: assert property (@(posedge clk) disable iff (rst)
        bad_fmt |-> !out_valid);

    // the flag is a single-cycle pulse
    assert_bad_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        bad_fmt |=> !bad_fmt);
endmodule

// File: tb/gpk_tag_parser_bench.sv
module gpk_tag_parser_bench;
    import gpk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NENT       = 8;

    typedef struct packed {
        logic [14:0] nloop;
        logic [3:0]  nreg;
        logic [1:0]  fmt;
        logic        eop;
        logic [63:0] descs;
        logic [19:0] exp_beats;
    } vec_t;

    localparam vec_t VECS [NENT] = '{
        '{15'd2, 4'd3, 2'b00, 1'b0, 64'hFEDC_BA98_7654_3210, 20'd6},
        '{15'd1, 4'd0, 2'b00, 1'b0, 64'h0123_4567_89AB_CDEF, 20'd16},
        '{15'd0, 4'd5, 2'b00, 1'b0, 64'h1111_2222_3333_4444, 20'd0},
        '{15'd3, 4'd3, 2'b01, 1'b0, 64'h5555_6666_7777_8888, 20'd5},
        '{15'd4, 4'd2, 2'b10, 1'b0, 64'h9999_AAAA_BBBB_CCCC, 20'd4},
        '{15'd3, 4'd1, 2'b00, 1'b1, 64'h0000_0000_0000_000D, 20'd3},
        '{15'd0, 4'd2, 2'b00, 1'b1, 64'hDDDD_EEEE_FFFF_0000, 20'd0},
        '{15'd2, 4'd2, 2'b11, 1'b1, 64'h1357_9BDF_2468_ACE0, 20'd2}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arm = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic [3:0]   out_desc;
    logic         out_last;
    logic         bad_fmt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    gpk_tag_parser u_gpk_tag_parser (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_desc  (out_desc),
        .out_last  (out_last),
        .bad_fmt   (bad_fmt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] make_tag(vec_t v);
        return {v.descs, v.nreg, v.fmt, 42'h0, v.eop, v.nloop};
    endfunction

    task automatic send_tag(input vec_t v, input int e);
        @(negedge clk);
        in_valid  = 1'b1;
        out_ready = 1'b1;
        in_data   = make_tag(v);
        #1;
        chk(in_ready == 1'b1, "R2", $sformatf("tag %0d accepted", e), 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R2", $sformatf("tag %0d not output", e), 128'(out_valid), 128'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(bad_fmt == (v.fmt != 2'b00), "R8", $sformatf("bad_fmt after tag %0d", e),
            128'(bad_fmt), 128'(v.fmt != 2'b00));
    endtask

    task automatic send_packed(input vec_t v, input int e);
        int nr;
        logic [127:0] d;
        logic [3:0]   ed;
        logic [3:0]   held;
        nr = (v.nreg == 4'd0) ? 16 : int'(v.nreg);
        for (int k = 0; k < int'(v.exp_beats); k++) begin
            d  = {16'(e), 16'(k), 96'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0};
            ed = v.descs[4*(k % nr) +: 4];
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = d;
            if ((k % 3) == 1) begin
                out_ready = 1'b0;
                #1;
                chk(out_valid && !in_ready, "R9", "stall passes back-pressure",
                    128'({out_valid, in_ready}), 128'b10);
                held = out_desc;
                @(negedge clk);
                #1;
                chk(out_desc == held && out_desc == ed, "R9", "descriptor held in stall",
                    128'(out_desc), 128'(ed));
            end
            out_ready = 1'b1;
            #1;
            chk(out_valid == 1'b1, "R3", $sformatf("beat %0d valid", k), 128'(out_valid), 128'd1);
            chk(out_data == d, "R3", $sformatf("beat %0d data", k), out_data, d);
            chk(out_desc == ed, "R4", $sformatf("entry %0d beat %0d desc", e, k),
                128'(out_desc), 128'(ed));
            chk(out_last == (k == int'(v.exp_beats) - 1), "R5", $sformatf("beat %0d last", k),
                128'(out_last), 128'(k == int'(v.exp_beats) - 1));
            @(posedge clk);
        end
    endtask

    task automatic send_skip(input vec_t v, input int e);
        for (int k = 0; k < int'(v.exp_beats); k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = {16'(e), 16'(k), 96'h0};
            #1;
            chk(in_ready && !out_valid, "R8", $sformatf("entry %0d discard %0d", e, k),
                128'({in_ready, out_valid}), 128'b10);
            if (k == 0)
                chk(bad_fmt == 1'b0, "R8", "bad_fmt single cycle", 128'(bad_fmt), 128'd0);
            @(posedge clk);
        end
    endtask

    task automatic finish_entry(input vec_t v, input int e);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (v.eop) begin
            chk(in_ready == 1'b0, "R7", $sformatf("idle after end packet %0d", e),
                128'(in_ready), 128'd0);
            in_valid = 1'b1;
            in_data  = '1;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                #1;
                chk(!in_ready && !out_valid, "R7", "idle ignores input",
                    128'({in_ready, out_valid}), 128'b00);
            end
            in_valid = 1'b0;
            arm      = 1'b1;
            @(negedge clk);
            arm = 1'b0;
            #1;
            chk(in_ready == 1'b1, "R7", "arm restarts tag parsing", 128'(in_ready), 128'd1);
        end else begin
            chk(in_ready && !out_valid, v.nloop == 0 ? "R6" : "R3",
                $sformatf("back to tag after entry %0d", e),
                128'({in_ready, out_valid}), 128'b10);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1", "reset in_ready", 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R1", "reset out_valid", 128'(out_valid), 128'd0);
        chk(bad_fmt == 1'b0, "R1", "reset bad_fmt", 128'(bad_fmt), 128'd0);

        for (int e = 0; e < NENT; e++) begin
            send_tag(VECS[e], e);
            if (VECS[e].fmt == 2'b00)
                send_packed(VECS[e], e);
            else
                send_skip(VECS[e], e);
            finish_entry(VECS[e], e);
        end

        // directed: arm outside idle leaves tag parsing unchanged (R7)
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        #1;
        chk(in_ready && !out_valid, "R7", "arm while waiting for tag", 128'({in_ready, out_valid}), 128'b10);

        // directed: reset in the middle of a payload returns to the tag wait (R1)
        send_tag(VECS[0], 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        #1;
        chk(in_ready && !out_valid && !bad_fmt, "R1", "mid-packet reset",
            128'({in_ready, out_valid, bad_fmt}), 128'b100);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule